// File: doc/BRIEF.md
# AAL1 Cell Header and Structure Pointer Generator

This block builds the opening bytes of every AAL1 cell that a segmentation engine emits. For each cell request it returns the SAR byte: a convergence-sublayer indication bit, a 3-bit sequence count kept separately for each queue, and a protection nibble. When the line runs in a structured mode it also decides whether this cell carries the structure pointer and what value that pointer holds. Its last output is the number of user-data octets the rest of the cell must supply.

A request names a queue, says whether the line is structured, and may report a structure boundary at a given octet offset inside the current cell's user-data block. The offset comes from the data path. For each queue the block tracks where the cell sits in the repeating cycle of eight sequence numbers. It places exactly one pointer per cycle, in the earliest even-numbered cell that can take it. If no boundary was reported in time, it falls back to a dummy pointer in cell six. All results appear one clock after the request.

Top module: `aal1_hdr_ptr_gen`

## Requirements
- R1: The SAR byte is laid out as bit 7 = CSI, bits 6:4 = sequence number, bits 3:1 = CRC-3 (generator x^3+x+1, message {CSI, SN} MSB first, remainder of message·x^3), and bit 0 = even parity over bits 7:1, so the whole byte has even parity.
- R2: Each queue's sequence number is 0 after reset and advances by one, modulo 8, on every request for that queue. Requests for other queues leave it unchanged.
- R3: A request accepted on one rising edge produces out_valid=1 and out_qid equal to the requested queue after that edge. A cycle with no request yields out_valid=0.
- R4: With struct_mode=0 the block places no pointer, whatever the boundary inputs say. ptr_present=0, ptr_byte=0 and payload_len=47.
- R5: With struct_mode=1 a pointer appears only in even cells (SN 0, 2, 4, 6), and at most once per queue in each cycle of SN 0 to 7.
- R6: In structured mode the pointer goes into the first even cell of the cycle that reports bnd_valid=1 with bnd_off ≤ 93. Its 7-bit value equals bnd_off, and this includes the end values 0 and 93.
- R7: A boundary reported with bnd_off greater than 93 is treated as no boundary.
- R8: If cells 0, 2 and 4 of a structured cycle carried no pointer, cell 6 carries one. Its value is bnd_off when a valid boundary is reported there, and 127 otherwise.
- R9: The pointer byte is bit 7 = even parity over bits 6:0 and bits 6:0 = pointer value.
- R10: CSI is 1 in a cell that carries a pointer. In an odd cell it follows the srts_bit input. In an even cell without a pointer it is 0.
- R11: payload_len is 46 when a pointer is present and 47 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_req | input | 1 | Request to build header bytes for one cell |
| cell_qid | input | QID_W (2) | Queue the cell belongs to |
| struct_mode | input | 1 | Line is in a structured mode |
| bnd_valid | input | 1 | A structure boundary is reported for this cell |
| bnd_off | input | 7 | Boundary octet offset within the user-data block |
| srts_bit | input | 1 | Clock-recovery bit placed in CSI of odd cells |
| out_valid | output | 1 | Result valid |
| out_qid | output | QID_W (2) | Queue of the result |
| sar_byte | output | 8 | First payload byte |
| ptr_present | output | 1 | This cell carries a structure pointer |
| ptr_byte | output | 8 | Pointer byte (0 when absent) |
| payload_len | output | 6 | User-data octet count for the cell |

## Verification
The bound checker watches several properties on every cycle. These are the parity of the SAR and pointer bytes, the one-cycle result timing, the modulo-8 sequence step per queue, the rule that a pointer appears only in an even cell and only once per cycle, the forced pointer in cell six, the absence of pointers in unstructured mode, and the tie between pointer presence and payload length. Two things need the bench's scenarios. Whether the pointer lands in the earliest qualifying cell with the right value is one. How offsets above 93 are rejected is the other. The bench sweeps every pattern of boundary reports across an eight-cell cycle and compares the CRC nibble and the CSI source against values it computes itself.

// File: rtl/aal1_ptr_pkg.sv
package aal1_ptr_pkg;

    localparam int SN_W        = 3;
    localparam int PTR_W       = 7;
    localparam int LEN_W       = 6;
    localparam int BLOCK_OCTS  = 93;
    localparam int DUMMY_VAL   = 127;
    localparam int DUMMY_CELL  = 6;
    localparam int LEN_NO_PTR  = 47;
    localparam int LEN_WITH_PTR = LEN_NO_PTR - 1;

    typedef struct packed {
        logic            csi;
        logic [SN_W-1:0] sn;
        logic [2:0]      crc;
        logic            par;
    } sar_byte_t;

    typedef struct packed {
        logic             par;
        logic [PTR_W-1:0] val;
    } ptr_byte_t;

    typedef enum logic [1:0] {
        PSEL_NONE     = 2'd0,
        PSEL_BOUNDARY = 2'd1,
        PSEL_DUMMY    = 2'd2
    } psel_e;

    typedef struct packed {
        logic [SN_W-1:0] sn;
        logic            done;
    } q_state_t;

    // Serial CRC-3, generator x^3+x+1, message MSB first.
    function automatic logic [2:0] crc3_calc(input logic [3:0] msg);
        logic [2:0] r;
        logic       fb;
        r = 3'b000;
        for (int i = 3; i >= 0; i--) begin
            fb = msg[i] ^ r[2];
            r  = {r[1], r[0] ^ fb, fb};
        end
        return r;
    endfunction

    function automatic logic even_par7(input logic [6:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/aal1_seq_state.sv
module aal1_seq_state
    import aal1_ptr_pkg::*;
#(
    parameter int NUM_QUEUES = 4,
    localparam int QID_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [QID_W-1:0] rd_qid,
    output q_state_t         rd_state,
    input  logic             wr_en,
    input  logic [QID_W-1:0] wr_qid,
    input  q_state_t         wr_state
);

    q_state_t st [NUM_QUEUES];

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
        always_ff @(posedge clk) begin
            if (rst) begin
                st[q] <= '0;
            end else if (wr_en && (wr_qid == QID_W'(q))) begin
                st[q] <= wr_state;
            end
        end
    end

    always_comb begin
        rd_state = '0;
        for (int q = 0; q < NUM_QUEUES; q++) begin
            if (rd_qid == QID_W'(q)) rd_state = st[q];
        end
    end

endmodule

// File: rtl/aal1_ptr_sel.sv
module aal1_ptr_sel
    import aal1_ptr_pkg::*;
(
    input  logic             struct_mode,
    input  logic [SN_W-1:0]  sn,
    input  logic             done_eff,
    input  logic             bnd_valid,
    input  logic [PTR_W-1:0] bnd_off,
    output psel_e            psel,
    output logic [PTR_W-1:0] ptr_val
);

    logic even_cell;
    logic bnd_ok;
    logic eligible;

    assign even_cell = ~sn[0];
    assign bnd_ok    = bnd_valid && (bnd_off <= PTR_W'(BLOCK_OCTS));
    assign eligible  = struct_mode && even_cell && !done_eff;

    always_comb begin
        psel    = PSEL_NONE;
        ptr_val = '0;
        if (eligible) begin
            if (bnd_ok) begin
                psel    = PSEL_BOUNDARY;
                ptr_val = bnd_off;
            end else if (sn == SN_W'(DUMMY_CELL)) begin
                psel    = PSEL_DUMMY;
                ptr_val = PTR_W'(DUMMY_VAL);
            end
        end
    end

endmodule

// File: rtl/aal1_sar_enc.sv
module aal1_sar_enc
    import aal1_ptr_pkg::*;
(
    input  logic             csi,
    input  logic [SN_W-1:0]  sn,
    input  logic             ptr_on,
    input  logic [PTR_W-1:0] ptr_val,
    output sar_byte_t        sar,
    output ptr_byte_t        ptr
);

    logic [2:0] crc;

    assign crc = crc3_calc({csi, sn});

    always_comb begin
        sar.csi = csi;
        sar.sn  = sn;
        sar.crc = crc;
        sar.par = even_par7({csi, sn, crc});
        if (ptr_on) begin
            ptr.val = ptr_val;
            ptr.par = even_par7(ptr_val);
        end else begin
            ptr = '0;
        end
    end

endmodule

// File: rtl/aal1_hdr_ptr_gen.sv
module aal1_hdr_ptr_gen
    import aal1_ptr_pkg::*;
#(
    parameter int NUM_QUEUES = 4,
    localparam int QID_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cell_req,
    input  logic [QID_W-1:0] cell_qid,
    input  logic             struct_mode,
    input  logic             bnd_valid,
    input  logic [PTR_W-1:0] bnd_off,
    input  logic             srts_bit,
    output logic             out_valid,
    output logic [QID_W-1:0] out_qid,
    output logic [7:0]       sar_byte,
    output logic             ptr_present,
    output logic [7:0]       ptr_byte,
    output logic [LEN_W-1:0] payload_len
);

    q_state_t         cur_st;
    q_state_t         nxt_st;
    logic             done_eff;
    psel_e            psel;
    logic [PTR_W-1:0] ptr_val;
    logic             place;
    logic             csi;
    sar_byte_t        sar_c;
    ptr_byte_t        ptr_c;

    aal1_seq_state #(.NUM_QUEUES(NUM_QUEUES)) state_i (
        .clk      (clk),
        .rst      (rst),
        .rd_qid   (cell_qid),
        .rd_state (cur_st),
        .wr_en    (cell_req),
        .wr_qid   (cell_qid),
        .wr_state (nxt_st)
    );

    // A new cycle opens at sequence number 0, clearing the pointer flag.
    assign done_eff = (cur_st.sn == '0) ? 1'b0 : cur_st.done;

    aal1_ptr_sel sel_i (
        .struct_mode (struct_mode),
        .sn          (cur_st.sn),
        .done_eff    (done_eff),
        .bnd_valid   (bnd_valid),
        .bnd_off     (bnd_off),
        .psel        (psel),
        .ptr_val     (ptr_val)
    );

    assign place = (psel != PSEL_NONE);
    assign csi   = place ? 1'b1 : (cur_st.sn[0] ? srts_bit : 1'b0);

    always_comb begin
        nxt_st.sn   = cur_st.sn + 1'b1;
        nxt_st.done = done_eff | place;
    end

    aal1_sar_enc enc_i (
        .csi     (csi),
        .sn      (cur_st.sn),
        .ptr_on  (place),
        .ptr_val (ptr_val),
        .sar     (sar_c),
        .ptr     (ptr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_qid     <= '0;
            sar_byte    <= '0;
            ptr_present <= 1'b0;
            ptr_byte    <= '0;
            payload_len <= LEN_W'(LEN_NO_PTR);
        end else begin
            out_valid <= cell_req;
            if (cell_req) begin
                out_qid     <= cell_qid;
                sar_byte    <= sar_c;
                ptr_present <= place;
                ptr_byte    <= ptr_c;
                payload_len <= place ? LEN_W'(LEN_WITH_PTR) : LEN_W'(LEN_NO_PTR);
            end
        end
    end

endmodule

// File: rtl/aal1_hdr_ptr_chk.sv
module aal1_hdr_ptr_chk
    import aal1_ptr_pkg::*;
#(
    parameter int NUM_QUEUES = 4,
    localparam int QID_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             cell_req,
    input logic             struct_mode,
    input logic             out_valid,
    input logic [QID_W-1:0] out_qid,
    input logic [7:0]       sar_byte,
    input logic             ptr_present,
    input logic [7:0]       ptr_byte,
    input logic [LEN_W-1:0] payload_len
);

    logic            seen   [NUM_QUEUES];
    logic [SN_W-1:0] last_sn[NUM_QUEUES];
    logic            sh_done[NUM_QUEUES];
    logic            struct_q;

    logic            seen_c;
    logic [SN_W-1:0] exp_sn;
    logic            done_c;
    logic [SN_W-1:0] out_sn;

    assign out_sn = sar_byte[6:4];

    always_comb begin
        seen_c = 1'b0;
        exp_sn = '0;
        done_c = 1'b0;
        for (int q = 0; q < NUM_QUEUES; q++) begin
            if (out_qid == QID_W'(q)) begin
                seen_c = seen[q];
                exp_sn = last_sn[q] + 1'b1;
                done_c = (out_sn == '0) ? 1'b0 : sh_done[q];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            struct_q <= 1'b0;
            for (int q = 0; q < NUM_QUEUES; q++) begin
                seen[q]    <= 1'b0;
                last_sn[q] <= '0;
                sh_done[q] <= 1'b0;
            end
        end else begin
            struct_q <= struct_mode;
            if (out_valid) begin
                for (int q = 0; q < NUM_QUEUES; q++) begin
                    if (out_qid == QID_W'(q)) begin
                        seen[q]    <= 1'b1;
                        last_sn[q] <= out_sn;
                        sh_done[q] <= done_c | ptr_present;
                    end
                end
            end
        end
    end

    // R1
    sar_parity_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (^sar_byte == 1'b0));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen_c) |-> (out_sn == exp_sn));

    // R3
    req_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (cell_req && !rst) |=> out_valid);

    // R3
    idle_to_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cell_req && !rst) |=> !out_valid);

    // R4
    unstruct_no_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !struct_q) |-> !ptr_present);

    // R5
    even_only_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ptr_present) |-> (out_sn[0] == 1'b0));

    // R5
    one_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ptr_present) |-> !done_c);

    // R8
    dummy_cell_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && struct_q && out_sn == SN_W'(DUMMY_CELL) && !done_c) |-> ptr_present);

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ptr_present) |->
            (ptr_byte[6:0] <= 7'(BLOCK_OCTS) || ptr_byte[6:0] == 7'(DUMMY_VAL)));

    // R9
    ptr_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ptr_present) |-> (^ptr_byte == 1'b0));

    // R10
    csi_with_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ptr_present) |-> sar_byte[7]);

    // R11
    len_match_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (payload_len == (ptr_present ? LEN_W'(LEN_WITH_PTR) : LEN_W'(LEN_NO_PTR))));

endmodule

bind aal1_hdr_ptr_gen aal1_hdr_ptr_chk #(.NUM_QUEUES(NUM_QUEUES)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cell_req    (cell_req),
    .struct_mode (struct_mode),
    .out_valid   (out_valid),
    .out_qid     (out_qid),
    .sar_byte    (sar_byte),
    .ptr_present (ptr_present),
    .ptr_byte    (ptr_byte),
    .payload_len (payload_len)
);

// File: tb/aal1_hdr_ptr_gen_tb_top.sv
`timescale 1ns/1ps
module aal1_hdr_ptr_gen_tb_top;

    localparam int NQ = 4;
    localparam int QW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          cell_req;
    logic [QW-1:0] cell_qid;
    logic          struct_mode;
    logic          bnd_valid;
    logic [6:0]    bnd_off;
    logic          srts_bit;
    logic          out_valid;
    logic [QW-1:0] out_qid;
    logic [7:0]    sar_byte;
    logic          ptr_present;
    logic [7:0]    ptr_byte;
    logic [5:0]    payload_len;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_sn  [NQ];
    bit m_done[NQ];

    always #2 clk = ~clk;

    aal1_hdr_ptr_gen #(.NUM_QUEUES(NQ)) dut_i (
        .clk(clk), .rst(rst), .cell_req(cell_req), .cell_qid(cell_qid),
        .struct_mode(struct_mode), .bnd_valid(bnd_valid), .bnd_off(bnd_off),
        .srts_bit(srts_bit), .out_valid(out_valid), .out_qid(out_qid),
        .sar_byte(sar_byte), .ptr_present(ptr_present), .ptr_byte(ptr_byte),
        .payload_len(payload_len)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Polynomial long division of {csi,sn}*x^3 by 1011.
    function automatic int crc_ref(input int msg4);
        int v;
        v = msg4 << 3;
        for (int b = 6; b >= 3; b--) begin
            if ((v >> b) & 1) v = v ^ (11 << (b - 3));
        end
        return v & 7;
    endfunction

    function automatic int par_of(input int v);
        int p;
        p = 0;
        for (int b = 0; b < 8; b++) p = p ^ ((v >> b) & 1);
        return p;
    endfunction

    task automatic send(input int q, input bit mode, input bit bv, input int off, input bit srts);
        int sn, val, csi, crc, sar, pbyte, len;
        bit de, place;
        string tag;
        sn = m_sn[q];
        de = (sn == 0) ? 1'b0 : m_done[q];
        place = 1'b0;
        val = 0;
        if (mode && (sn % 2 == 0) && !de) begin
            if (bv && off <= 93) begin place = 1'b1; val = off; end
            else if (sn == 6) begin place = 1'b1; val = 127; end
        end
        csi = place ? 1 : ((sn % 2 == 1) ? int'(srts) : 0);
        crc = crc_ref(csi * 8 + sn);
        sar = csi * 128 + sn * 16 + crc * 2;
        sar = sar + par_of(sar);
        pbyte = place ? (par_of(val) * 128 + val) : 0;
        len = place ? 46 : 47;
        if (!mode) tag = "R4";
        else if (place && val == 127) tag = "R8";
        else if (bv && off > 93) tag = "R7";
        else tag = "R6";
        m_sn[q] = (sn + 1) % 8;
        m_done[q] = de | place;

        cell_req = 1'b1; cell_qid = QW'(q); struct_mode = mode;
        bnd_valid = bv; bnd_off = 7'(off); srts_bit = srts;
        @(posedge clk);
        @(negedge clk);
        chk("R3 out_valid", int'(out_valid), 1);
        chk("R3 out_qid", int'(out_qid), q);
        chk("R2 sequence number", int'(sar_byte[6:4]), sn);
        chk("R10 CSI", int'(sar_byte[7]), csi);
        chk("R1 CRC and parity", int'(sar_byte[3:0]), sar & 15);
        chk({tag, " ptr_present"}, int'(ptr_present), int'(place));
        chk({tag, " ptr value"}, int'(ptr_byte[6:0]), pbyte & 127);
        chk("R9 pointer parity", int'(ptr_byte[7]), pbyte >> 7);
        chk("R11 payload length", int'(payload_len), len);
        if (mode) chk("R5 pointer cell even", int'(place && (sn % 2 == 1)), 0);
        cell_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cell_req = 1'b0; cell_qid = '0; struct_mode = 1'b0;
        bnd_valid = 1'b0; bnd_off = '0; srts_bit = 1'b0;
        for (int q = 0; q < NQ; q++) begin m_sn[q] = 0; m_done[q] = 1'b0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R3 reset out_valid", int'(out_valid), 0);
        chk("R11 reset payload length", int'(payload_len), 47);

        // Unstructured: boundaries offered but must be ignored (R4); 16 cells per queue realigns SN.
        for (int c = 0; c < 16; c++) begin
            for (int q = 0; q < NQ; q++) begin
                send(q, 1'b0, 1'b1, (c * 13) % 94, bit'((c + q) % 2));
            end
        end

        // Idle cycle (R3).
        @(posedge clk);
        @(negedge clk);
        chk("R3 idle out_valid", int'(out_valid), 0);

        // Structured: every boundary-report mask over an 8-cell cycle (R5 R6 R7 R8).
        for (int pat = 0; pat < 256; pat++) begin
            for (int c = 0; c < 8; c++) begin
                send(pat % NQ, 1'b1, bit'((pat >> c) & 1), (pat * 37 + c * 11) % 128,
                     bit'(((pat >> c) & 1) ^ (c & 1)));
            end
        end

        // Directed end values and rejected offsets in cell 2 (R6 R7 R8).
        for (int k = 0; k < 4; k++) begin
            int offs;
            offs = (k == 0) ? 0 : (k == 1) ? 93 : (k == 2) ? 94 : 127;
            for (int c = 0; c < 8; c++) begin
                send(0, 1'b1, (c == 2), offs, 1'b1);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule